// File: doc/BRIEF.md
# Output Feedback Block Sequencer

This block applies a 128-bit block cipher in output feedback fashion to a stream of 32-bit words. It keeps a feedback register that is loaded with an initialization value. Through a request/done handshake it asks an external cipher engine to encrypt that register. Each encryption result is one keystream block, and it also becomes the next value of the feedback register. The keystream therefore never depends on the data. Four input words make one block, and that block is XORed with the keystream block for its position. The result leaves as four output words.

Data enters on a valid/ready word stream and leaves on a valid/ready word stream. The flow rules differ from plain back-pressure:

- **Input.** The sender may raise `in_valid` only in a cycle where `in_ready` is already high. A word is taken on the edge where both are high.
- **Output.** The receiver raises `out_ready` only while `out_valid` is high, and it takes one word on each such edge.
- **Stalls.** The block applies back-pressure by holding a ready or valid low. A word offered against a low ready, or a read attempted against a low valid, is dropped and recorded in a sticky error flag.

An encoded status index and two single-transfer DMA request lines let an interrupt handler or a DMA engine drive the same streams.

The sequencer fetches keystream ahead of the data. The next encryption is requested as soon as the current keystream block is known, so the XOR waits only for input words. Loading a new initialization value or pulsing `restart` does the following:

- discards any partial input block and any unread output block;
- discards a cipher result still in flight;
- restarts the keystream chain from the stored initialization value.

Top module: `ofb_stream_sequencer`

## Requirements
- R1: After reset `irq_idx` reads 2, `in_ready` is 1, `out_valid` is 0, `proto_err` is 0, and the stored initialization value is zero.
- R2: Keystream block 0 is the encryption of the initialization value. Keystream block n+1 is the encryption of keystream block n.
- R3: Output block n equals input block n XOR keystream block n.
- R4: Input word k (k = 0..3) fills bits [32k+31:32k] of the block, so the first word is least significant. Output words leave in the same order, least significant first.
- R5: `irq_idx` reads 1 while an output block is ready, 2 while input can be taken and no output is ready, and 0 otherwise. Output-ready takes priority over input-ready. The edge that reads the last output word clears output-ready.
- R6: `dma_in_trig` is high only while `in_ready` is high, and `dma_out_trig` is high only while `out_valid` is high. After a trigger, no further trigger is raised on that side until one word has moved there. Over a run without flushes, each side raises as many trigger cycles as words it moved.
- R7: Successive blocks continue the keystream chain without reloading the initialization value.
- R8: A pulse on `iv_load` (which also stores `iv_value`) or on `restart` clears any partial input block and any pending output block. It restarts the keystream from the stored initialization value. The cycle after the pulse shows `in_ready` 1, `out_valid` 0 and `irq_idx` 2.
- R9: A word offered while `in_ready` is 0, or a read while `out_valid` is 0, changes no data and sets `proto_err`. `proto_err` stays set until reset.
- R10: With no input, the block completes exactly two encryptions ahead and then leaves `ck_req` low.
- R11: While all four input words are held but the block cannot advance, `in_ready` stays 0. While `out_valid` is 1 and no read occurs, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart from the stored initialization value |
| iv_load | input | 1 | Store `iv_value` and restart from it |
| iv_value | input | 128 | New initialization value |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Receiver takes the output word |
| out_data | output | 32 | Output word |
| ck_req | output | 1 | Encryption request, held until `ck_done` |
| ck_data | output | 128 | Block to encrypt, stable while `ck_req` is high |
| ck_done | input | 1 | One-cycle completion from the cipher engine |
| ck_result | input | 128 | Encrypted block, valid with `ck_done` |
| irq_idx | output | 2 | Status index: 0 none, 1 output ready, 2 input ready |
| dma_in_trig | output | 1 | Request for one input word transfer |
| dma_out_trig | output | 1 | Request for one output word transfer |
| proto_err | output | 1 | Sticky flow-rule violation flag |

## Verification
Timing of each result:

- **Input side.** A word is taken on the edge where `in_valid` and `in_ready` are both high. The edge taking the fourth word drops `in_ready`.
- **XOR.** The XOR is registered on the first edge where all four words, a keystream block and an empty output buffer are present. From that edge `out_valid`, `irq_idx`=1 and `dma_out_trig` are visible.
- **Output side.** The edge that takes the last output word clears output-ready.
- **Control inputs.** A flow violation, a restart or an initialization load shows its effect one edge later.

How the checks keep to that timing:

- The bench changes inputs on the falling edge and reads outputs on the falling edge, half a cycle after the edge that produced them.
- The stand-in cipher answers after a random or a fixed latency. For that reason, data results are awaited by polling `out_valid` and `in_ready` on falling edges.
- Reset state, error flag, flush and status-priority results are checked at the exact falling edge that follows their cause.

// File: rtl/ofb_pkg.sv
package ofb_pkg;
  typedef enum logic [1:0] {
    IRQ_IDLE    = 2'd0,
    IRQ_OUT_RDY = 2'd1,
    IRQ_IN_RDY  = 2'd2
  } irq_code_e;
endpackage

// File: rtl/ofb_word_pack.sv
module ofb_word_pack #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output logic              ready,
  output logic              full,
  output logic [BLK_W-1:0]  block
);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CNT_W-1:0]             cnt_q;
  logic [WORDS-1:0][WORD_W-1:0] lane_q;
  logic                         wr_fire;

  assign full    = (cnt_q == CNT_W'(WORDS));
  assign ready   = !full;
  assign wr_fire = wr_valid && ready && !flush;
  assign block   = lane_q;

  // lane 0 is filled first and sits in the least significant bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lane_q <= '0;
    end else if (flush || take) begin
      cnt_q <= '0;
    end else if (wr_fire) begin
      lane_q[cnt_q[IDX_W-1:0]] <= wr_data;
      cnt_q                    <= cnt_q + 1'b1;
    end
  end

  AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full); // R3
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !take && !flush |=> full && !ready); // R11
endmodule

// File: rtl/ofb_ks_engine.sv
module ofb_ks_engine #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] load_val,
  input  logic             consume,
  output logic             ks_valid,
  output logic [BLK_W-1:0] ks_data,
  output logic             ck_req,
  output logic [BLK_W-1:0] ck_data,
  input  logic             ck_done,
  input  logic [BLK_W-1:0] ck_result
);
  logic [BLK_W-1:0] fb_q, cur_q, nxt_q, req_data_q;
  logic             cur_v, nxt_v, req_q, drop_q;
  logic             done_ok, start;

  // a result is kept only if no reload happened while it was in flight
  assign done_ok  = ck_done && req_q && !drop_q;
  // fetch ahead until both keystream slots are spoken for
  assign start    = !req_q && !nxt_v && !load;
  assign ck_req   = req_q;
  assign ck_data  = req_data_q;
  assign ks_valid = cur_v;
  assign ks_data  = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q       <= '0;
      cur_q      <= '0;
      nxt_q      <= '0;
      req_data_q <= '0;
      cur_v      <= 1'b0;
      nxt_v      <= 1'b0;
      req_q      <= 1'b0;
      drop_q     <= 1'b0;
    end else begin
      if (req_q && ck_done) begin
        req_q  <= 1'b0;
        drop_q <= 1'b0;
      end else if (start) begin
        req_q      <= 1'b1;
        req_data_q <= fb_q;
      end

      if (load) begin
        fb_q  <= load_val;
        cur_v <= 1'b0;
        nxt_v <= 1'b0;
        if (req_q && !ck_done) drop_q <= 1'b1;
      end else begin
        if (done_ok) fb_q <= ck_result;
        if (consume) begin
          if (nxt_v) begin
            cur_q <= nxt_q;
            nxt_v <= 1'b0;
          end else if (done_ok) begin
            cur_q <= ck_result;
          end else begin
            cur_v <= 1'b0;
          end
        end else if (done_ok) begin
          if (!cur_v) begin
            cur_q <= ck_result;
            cur_v <= 1'b1;
          end else begin
            nxt_q <= ck_result;
            nxt_v <= 1'b1;
          end
        end
      end
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !ck_done |=> req_q && $stable(req_data_q)); // R2
  AST_CONSUME_HAS_KS: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> cur_v); // R3
  AST_NO_SLOT_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> !(cur_v && nxt_v)); // R10
endmodule

// File: rtl/ofb_word_unpack.sv
module ofb_word_unpack #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [BLK_W-1:0]  load_blk,
  input  logic              rd,
  output logic              full,
  output logic [WORD_W-1:0] rd_data
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  logic [WORDS-1:0][WORD_W-1:0] buf_q;
  logic [IDX_W-1:0]             idx_q;
  logic                         full_q;

  assign full    = full_q;
  assign rd_data = buf_q[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (flush) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      buf_q  <= load_blk;
      idx_q  <= '0;
      full_q <= 1'b1;
    end else if (full_q && rd) begin
      if (idx_q == LAST) begin
        idx_q  <= '0;
        full_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full_q); // R3
  AST_LAST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && rd && (idx_q == LAST) && !flush |=> !full_q); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !rd && !flush |=> full_q && $stable(rd_data)); // R11
endmodule

// File: rtl/ofb_dma_pulse.sv
module ofb_dma_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic want,
  input  logic moved,
  output logic trig
);
  logic pend_q;

  // one request outstanding per side; a moved word re-arms it
  assign trig = want && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (flush)  pend_q <= 1'b0;
    else if (moved)  pend_q <= 1'b0;
    else if (trig)   pend_q <= 1'b1;
  end

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !moved && !flush |=> !trig); // R6
endmodule

// File: rtl/ofb_stream_sequencer.sv
module ofb_stream_sequencer #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              iv_load,
  input  logic [BLK_W-1:0]  iv_value,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              ck_req,
  output logic [BLK_W-1:0]  ck_data,
  input  logic              ck_done,
  input  logic [BLK_W-1:0]  ck_result,
  output logic [1:0]        irq_idx,
  output logic              dma_in_trig,
  output logic              dma_out_trig,
  output logic              proto_err
);
  import ofb_pkg::*;

  logic [BLK_W-1:0] iv_q, load_val, in_blk, ks_blk;
  logic             flush, in_full, ks_valid, fire, err_q;
  logic             in_fire, out_fire;
  irq_code_e        irq_c;

  assign flush    = restart || iv_load;
  assign load_val = iv_load ? iv_value : iv_q;
  assign fire     = in_full && ks_valid && !out_valid && !flush;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_ready && out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       iv_q <= '0;
    else if (iv_load) iv_q <= iv_value;
  end

  ofb_word_pack #(.WORD_W(WORD_W), .WORDS(WORDS)) u_pack (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_valid(in_valid), .wr_data(in_data), .take(fire),
    .ready(in_ready), .full(in_full), .block(in_blk)
  );

  ofb_ks_engine #(.BLK_W(BLK_W)) u_ks (
    .clk(clk), .rst_n(rst_n), .load(flush), .load_val(load_val),
    .consume(fire), .ks_valid(ks_valid), .ks_data(ks_blk),
    .ck_req(ck_req), .ck_data(ck_data),
    .ck_done(ck_done), .ck_result(ck_result)
  );

  ofb_word_unpack #(.WORD_W(WORD_W), .WORDS(WORDS)) u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .load(fire), .load_blk(in_blk ^ ks_blk), .rd(out_ready),
    .full(out_valid), .rd_data(out_data)
  );

  for (genvar s = 0; s < 2; s++) begin : g_trig
    if (s == 0) begin : g_in
      ofb_dma_pulse u_pulse (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .want(in_ready), .moved(in_fire), .trig(dma_in_trig)
      );
    end else begin : g_out
      ofb_dma_pulse u_pulse (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .want(out_valid), .moved(out_fire), .trig(dma_out_trig)
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if ((in_valid && !in_ready) || (out_ready && !out_valid)) err_q <= 1'b1;
  end
  assign proto_err = err_q;

  always_comb begin
    if (out_valid)     irq_c = IRQ_OUT_RDY;
    else if (in_ready) irq_c = IRQ_IN_RDY;
    else               irq_c = IRQ_IDLE;
  end
  assign irq_idx = irq_c;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R9
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && in_ready); // R8
  AST_TRIG_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_in_trig |-> in_ready) and (dma_out_trig |-> out_valid)); // R6
endmodule

// File: tb/tb_ofb_stream_sequencer.sv
`timescale 1ns/1ps
module tb_ofb_stream_sequencer;
  localparam int WW = 32;
  localparam int NW = 4;
  localparam int BW = WW * NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          restart = 1'b0, iv_load = 1'b0;
  logic [BW-1:0] iv_value = '0;
  logic          in_valid = 1'b0, in_ready;
  logic [WW-1:0] in_data = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [WW-1:0] out_data;
  logic          ck_req, ck_done = 1'b0;
  logic [BW-1:0] ck_data, ck_result = '0;
  logic [1:0]    irq_idx;
  logic          dma_in_trig, dma_out_trig, proto_err;

  int checks = 0, errors = 0;
  int done_cnt = 0, lat_left = 0, force_lat = 0;
  int in_trig_cnt = 0, out_trig_cnt = 0, words_in = 0, words_out = 0;
  logic [BW-1:0] m_ks, cur_iv;
  logic [BW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  ofb_stream_sequencer dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .iv_load(iv_load),
    .iv_value(iv_value), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .ck_req(ck_req), .ck_data(ck_data),
    .ck_done(ck_done), .ck_result(ck_result), .irq_idx(irq_idx),
    .dma_in_trig(dma_in_trig), .dma_out_trig(dma_out_trig),
    .proto_err(proto_err)
  );

  function automatic logic [BW-1:0] mix(input logic [BW-1:0] x);
    return {x[98:0], x[127:99]} ^ (x >> 11) ^ 128'h9e3779b97f4a7c15f39cc0605cedc834;
  endfunction

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stand-in cipher engine, answers on falling edges
  always @(negedge clk) begin
    if (!rst_n) begin
      ck_done  = 1'b0;
      lat_left = 0;
    end else if (ck_done) begin
      ck_done = 1'b0;
    end else if (ck_req) begin
      if (lat_left == 0) lat_left = (force_lat != 0) ? force_lat : 1 + int'($urandom % 3);
      lat_left--;
      if (lat_left == 0) begin
        ck_result = mix(ck_data);
        ck_done   = 1'b1;
        done_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (dma_in_trig)  in_trig_cnt++;
    if (dma_out_trig) out_trig_cnt++;
  end

  task automatic push_word(input logic [WW-1:0] w);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
    words_in++;
  endtask

  task automatic push_block(input logic [BW-1:0] pt);
    for (int i = 0; i < NW; i++) push_word(pt[WW*i +: WW]);
    exp_q.push_back(pt ^ m_ks);
    m_ks = mix(m_ks);
  endtask

  task automatic pop_block();
    logic [BW-1:0] e;
    e = exp_q.pop_front();
    for (int i = 0; i < NW; i++) begin
      while (!out_valid) @(negedge clk);
      check(out_data == e[WW*i +: WW], $sformatf("R2 R3 R4 word %0d", i),
            BW'(out_data), BW'(e[WW*i +: WW]));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      words_out++;
    end
  endtask

  task automatic pulse_restart(input bit new_iv, input logic [BW-1:0] v);
    if (new_iv) begin
      iv_load  = 1'b1;
      iv_value = v;
      cur_iv   = v;
    end else begin
      restart = 1'b1;
    end
    @(negedge clk);
    iv_load = 1'b0;
    restart = 1'b0;
    exp_q.delete();
    m_ks = mix(cur_iv);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n    = 1'b1;
    done_cnt = 0;
    cur_iv   = '0;
    m_ks     = mix('0);
    exp_q.delete();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] held;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R1 reset values
    check(irq_idx == 2'd2, "R1 irq_idx", BW'(irq_idx), 2);
    check(in_ready && !out_valid, "R1 ready/valid", BW'({in_ready, out_valid}), 2);
    check(!proto_err, "R1 proto_err", BW'(proto_err), 0);

    // R9 read with nothing to read
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(proto_err && !out_valid, "R9 read while empty", BW'({proto_err, out_valid}), 2);
    repeat (2) @(negedge clk);
    check(proto_err, "R9 sticky", BW'(proto_err), 1);

    do_reset();
    check(!proto_err, "R1 proto_err after reset", BW'(proto_err), 0);

    // R10 prefetch depth with no input
    repeat (30) @(negedge clk);
    check(done_cnt == 2 && !ck_req, "R10 prefetch depth", BW'(done_cnt), 2);

    in_trig_cnt = 0; out_trig_cnt = 0; words_in = 0; words_out = 0;

    // R4 directed word order
    push_block({32'd4, 32'd3, 32'd2, 32'd1});
    pop_block();

    // R5 priority: output ready while input also ready
    push_block({4{32'hA5A5_0F0F}});
    while (!out_valid) @(negedge clk);
    check(irq_idx == 2'd1 && in_ready, "R5 output first", BW'({irq_idx, in_ready}), 3'b011);
    pop_block();
    check(irq_idx == 2'd2, "R5 cleared by last read", BW'(irq_idx), 2);

    // R11 and R9: second block stalls behind unread first block
    push_block({32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888});
    push_block({32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_D00D, 32'h1234_5678});
    @(negedge clk);
    held = out_data;
    check(!in_ready && out_valid, "R11 input stalled", BW'({in_ready, out_valid}), 1);
    in_valid = 1'b1;
    in_data  = 32'hFFFF_FFFF;
    @(negedge clk);
    in_valid = 1'b0;
    check(proto_err, "R9 write while not ready", BW'(proto_err), 1);
    repeat (2) @(negedge clk);
    check(out_data == held && !in_ready, "R11 output held", BW'(out_data), BW'(held));
    pop_block();
    pop_block();

    // R7 constrained random stream, up to two blocks in flight
    for (int b = 0; b < 24; b++) begin
      push_block({$urandom, $urandom, $urandom, $urandom});
      if (exp_q.size() >= 2 || ($urandom % 2) == 0) pop_block();
      repeat ($urandom % 3) @(negedge clk);
    end
    while (exp_q.size() != 0) pop_block();
    repeat (3) @(negedge clk);
    check(in_trig_cnt == words_in, "R6 input triggers", BW'(in_trig_cnt), BW'(words_in));
    check(out_trig_cnt == words_out, "R6 output triggers", BW'(out_trig_cnt), BW'(words_out));

    // R5 idle code with a slow cipher, R8 new IV with partial block
    force_lat = 15;
    push_word(32'h0101_0101);
    push_word(32'h0202_0202);
    pulse_restart(1'b1, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    check(in_ready && !out_valid && irq_idx == 2'd2, "R8 flush after iv load",
          BW'({in_ready, out_valid, irq_idx}), 4'b1010);
    push_block({32'h0, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE});
    check(irq_idx == 2'd0 && !in_ready, "R5 idle code", BW'({irq_idx, in_ready}), 0);
    pop_block();

    // R8 restart with cipher request in flight and partial block
    push_block({$urandom, $urandom, $urandom, $urandom});
    pop_block();
    push_word(32'h5A5A_5A5A);
    pulse_restart(1'b0, '0);
    check(in_ready && !out_valid, "R8 restart flush", BW'({in_ready, out_valid}), 2);
    push_block({$urandom, $urandom, $urandom, $urandom});
    pop_block();

    // R8 restart discards an unread output block
    force_lat = 0;
    push_block({$urandom, $urandom, $urandom, $urandom});
    while (!out_valid) @(negedge clk);
    pulse_restart(1'b0, '0);
    check(!out_valid && irq_idx == 2'd2, "R8 output discarded", BW'({out_valid, irq_idx}), 2);
    push_block({$urandom, $urandom, $urandom, $urandom});
    push_block({$urandom, $urandom, $urandom, $urandom});
    pop_block();
    pop_block();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule